// File: doc/BRIEF.md
# Hash Message Input Front-End

This block is the input side of a hash accelerator. Software, or a DMA channel, writes 32-bit message words into a data register over a simple write port with a valid/ready handshake. Each word is reordered according to a selectable data type and is queued in a holding buffer. The block then releases whole blocks to an external compression engine, one word per cycle over a valid/ready stream. The engine itself sits outside the block. The front-end only decides when a block may go, and it marks each beat of the stream.

The release rule keeps one word in reserve at all times. The first block leaves only after one block plus one extra word has arrived. Each later block leaves once another full block has arrived. A final-calculation command flushes the words still held. It tags the last beat with the number of valid bits from a 5-bit count, or it sends a single empty beat when nothing is held. The engine answers with a done pulse, and that pulse raises the output-ready flag.

Status flags report input-ready, output-ready, DMA-enabled and busy. A level interrupt combines the enabled flags. A burst DMA request asks for data while at least one burst of space is free. When DMA is used, the end of a DMA stream can start the final calculation. In multi-transfer mode it does not, and an abort bit switches DMA off so that software can write the tail.

Top module: `hash_msg_frontend`

## Requirements
- R1: After reset, the status vector `stat_flags` reads 4'b0001 (bit 0 input-ready set; bit 1 output-ready, bit 2 DMA-enabled and bit 3 busy clear), and `eng_valid`, `irq` and `dma_req` are low.
- R2: The control field at bits [5:4] selects how each data word is reordered before it is queued: 0 keeps the word, 1 exchanges its two 16-bit halves, 2 reverses its byte order and 3 reverses its bit order.
- R3: With BLOCK_WORDS words queued and no final command, no beat is offered to the engine and busy stays clear; one more word starts the release of a block.
- R4: A released block is streamed as BLOCK_WORDS beats in write order, with `eng_last` on the last beat only and `eng_final` low; the newest word stays queued, and the next block is released after BLOCK_WORDS further words.
- R5: A data write that finds the buffer (2×BLOCK_WORDS words) full sees `wr_ready` low and input-ready clear; the write is held, not lost, and its word is delivered once space frees.
- R6: Writing the start register with bit 8 set streams all queued words with `eng_final` high, with `eng_last` on the last one and `eng_nbits` equal to start bits [4:0]; if no word is queued, a single beat with `eng_empty`, `eng_last` and `eng_final` high is sent.
- R7: Busy (status bit 3) is set while a block or the final words are pending or streaming and while the digest is awaited; `eng_done` in that wait clears busy and sets output-ready (status bit 1).
- R8: Output-ready is cleared by a status-register write with bit 1 at 0, or by an init.
- R9: A control write with bit 2 set empties the buffer and restarts counting, so a new message again needs BLOCK_WORDS+1 words before the first release.
- R10: With DMA enabled (control bit 3), `dma_req` is high while input is accepted and at least BURST words of buffer space are free, and is low otherwise, including while a final calculation is pending or running.
- R11: A `dma_end` pulse starts the final calculation when DMA is enabled and the multi-transfer bit (control bit 13) is clear; it has no effect when that bit is set; control bit 14 disables DMA, so status bit 2 and `dma_req` fall.
- R12: `irq` is high when mask bit 0 is set and input-ready is set, or mask bit 1 is set and output-ready is set; otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted this cycle (low only for a data write that must wait) |
| wr_addr | input | 3 | Register select: 0 control, 1 data, 2 start, 3 mask, 4 status |
| wr_data | input | DATA_W | Write data |
| stat_flags | output | 4 | {busy, DMA enabled, output-ready, input-ready} |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | Burst request to the DMA channel |
| dma_end | input | 1 | Pulse marking the end of a DMA stream |
| eng_restart | output | 1 | One-cycle pulse after init, restarting the engine state |
| eng_valid | output | 1 | Beat offered to the engine |
| eng_ready | input | 1 | Engine takes the beat |
| eng_data | output | DATA_W | Reordered message word |
| eng_last | output | 1 | Last beat of a block |
| eng_final | output | 1 | Beat belongs to the final, padded block |
| eng_empty | output | 1 | Final beat carries no data (empty message) |
| eng_nbits | output | 5 | Valid bits in the last final word, 0 meaning all |
| eng_done | input | 1 | Engine finished the digest |

## Verification
The assertions assume that `eng_done` comes only after the final beat has been taken. They also assume that a start command is not issued while a block is streaming, and that `dma_end` is pulsed only when the DMA channel has really finished. The bench keeps to these rules. It waits until busy has cleared and the stream has drained before each final command, and it pulses `eng_done` only once the final beat has been seen. It sweeps all four reorder modes over several word patterns in a four-word-block configuration, and it stalls the engine on purpose to fill the buffer.

// File: rtl/hmf_pkg.sv
package hmf_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_DIN   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_START = 3'd2;
  localparam logic [ADDR_W-1:0] RA_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd4;

  localparam int CB_INIT  = 2;
  localparam int CB_DMA   = 3;
  localparam int CB_DT    = 4;
  localparam int CB_MULTI = 13;
  localparam int CB_ABORT = 14;
  localparam int SB_GO    = 8;
  localparam int STB_OUT  = 1;

  typedef enum logic [1:0] {
    DT_WORD = 2'd0,
    DT_HALF = 2'd1,
    DT_BYTE = 2'd2,
    DT_BIT  = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    SQ_FILL  = 2'd0,
    SQ_BLOCK = 2'd1,
    SQ_LAST  = 2'd2,
    SQ_WAIT  = 2'd3
  } seq_e;
endpackage

// File: rtl/hmf_swap.sv
module hmf_swap
  import hmf_pkg::*;
#(
  parameter int W = 32
) (
  input  dtype_e         mode,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   dout
);
  localparam int NB = W / 8;
  localparam int HW = W / 2;

  logic [W-1:0] by_rev;
  logic [W-1:0] bit_rev;
  logic [W-1:0] half_sw;

  assign half_sw = {din[HW-1:0], din[W-1:HW]};

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign by_rev[8*b +: 8] = din[W-8-8*b +: 8];
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_rev[i] = din[W-1-i];
  end

  always_comb begin
    case (mode)
      DT_HALF: dout = half_sw;
      DT_BYTE: dout = by_rev;
      DT_BIT:  dout = bit_rev;
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/hmf_buf.sv
module hmf_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] cnt,
  output logic          full
);
  localparam logic [AW-1:0] LASTP = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= step(wp_q);
      if (pop)  rp_q <= step(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata = mem[rp_q];
  assign cnt   = cnt_q;
  assign full  = (cnt_q == FULLC);
endmodule

// File: rtl/hmf_seq.sv
module hmf_seq
  import hmf_pkg::*;
#(
  parameter int BLK = 16,
  parameter int CW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          fin_go,
  input  logic [CW-1:0] cnt,
  input  logic          eng_ready,
  input  logic          eng_done,
  output logic          eng_valid,
  output logic          eng_last,
  output logic          eng_final,
  output logic          eng_empty,
  output logic          pop,
  output logic          accept,
  output logic          busy,
  output logic          out_set
);
  localparam int SW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [SW-1:0] LAST_IDX = SW'(BLK - 1);
  localparam logic [CW-1:0] REL      = CW'(BLK + 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  seq_e          st_q;
  logic [SW-1:0] sent_q;
  logic          pend_q;
  logic          rel_now;

  assign rel_now = (cnt >= REL);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      st_q   <= SQ_FILL;
      sent_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (fin_go && (st_q == SQ_FILL || st_q == SQ_BLOCK)) pend_q <= 1'b1;
      case (st_q)
        SQ_FILL: begin
          if (rel_now) begin
            st_q   <= SQ_BLOCK;
            sent_q <= '0;
          end else if (pend_q) begin
            st_q   <= SQ_LAST;
            pend_q <= 1'b0;
          end
        end
        SQ_BLOCK: begin
          if (eng_ready) begin
            sent_q <= sent_q + 1'b1;
            if (sent_q == LAST_IDX) st_q <= SQ_FILL;
          end
        end
        SQ_LAST: begin
          if (eng_ready && cnt <= ONE) st_q <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (eng_done) st_q <= SQ_FILL;
        end
        default: st_q <= SQ_FILL;
      endcase
    end
  end

  assign eng_valid = (st_q == SQ_BLOCK) || (st_q == SQ_LAST);
  assign eng_final = (st_q == SQ_LAST);
  assign eng_empty = (st_q == SQ_LAST) && (cnt == '0);
  assign eng_last  = (st_q == SQ_BLOCK) ? (sent_q == LAST_IDX)
                                        : ((st_q == SQ_LAST) && (cnt <= ONE));
  assign pop       = eng_valid && eng_ready && !eng_empty;
  assign accept    = ((st_q == SQ_FILL) || (st_q == SQ_BLOCK)) && !pend_q;
  assign busy      = (st_q != SQ_FILL) || pend_q || rel_now;
  assign out_set   = (st_q == SQ_WAIT) && eng_done;
endmodule

// File: rtl/hash_msg_frontend.sv
module hash_msg_frontend
  import hmf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 16,
  parameter int BURST       = 4,
  localparam int FIFO_DEPTH = 2 * BLOCK_WORDS,
  localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [3:0]        stat_flags,
  output logic              irq,
  output logic              dma_req,
  input  logic              dma_end,
  output logic              eng_restart,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [DATA_W-1:0] eng_data,
  output logic              eng_last,
  output logic              eng_final,
  output logic              eng_empty,
  output logic [4:0]        eng_nbits,
  input  logic              eng_done
);
  localparam logic [CW-1:0] FULLC  = CW'(FIFO_DEPTH);
  localparam logic [CW-1:0] BURSTC = CW'(BURST);

  dtype_e          dtype_q;
  logic            dma_en_q, multi_q, out_rdy_q, irq_q, dma_req_q, restart_q;
  logic [4:0]      nbits_q;
  logic [1:0]      ie_q;

  logic            din_sel, wr_fire, ctrl_wr, init_pulse, din_push;
  logic            start_wr, fin_go, stat_clr, din_ok;
  logic [DATA_W-1:0] swapped;
  logic [CW-1:0]   fifo_cnt;
  logic            fifo_full, pop, accept, busy, out_set;
  logic            unused_wr;

  assign din_sel    = (wr_addr == RA_DIN);
  assign din_ok     = accept && !fifo_full;
  assign wr_ready   = !din_sel || din_ok;
  assign wr_fire    = wr_valid && wr_ready;
  assign ctrl_wr    = wr_fire && (wr_addr == RA_CTRL);
  assign init_pulse = ctrl_wr && wr_data[CB_INIT];
  assign din_push   = wr_fire && din_sel;
  assign start_wr   = wr_fire && (wr_addr == RA_START);
  assign stat_clr   = wr_fire && (wr_addr == RA_STAT) && !wr_data[STB_OUT];
  assign fin_go     = (start_wr && wr_data[SB_GO]) ||
                      (dma_end && dma_en_q && !multi_q);
  assign unused_wr  = ^{wr_data[DATA_W-1:15], wr_data[12:9], wr_data[7:6]};

  hmf_swap #(.W(DATA_W)) u_swap (
    .mode (dtype_q),
    .din  (wr_data),
    .dout (swapped)
  );

  hmf_buf #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk   (clk),
    .rst   (rst),
    .clr   (init_pulse),
    .push  (din_push),
    .wdata (swapped),
    .pop   (pop),
    .rdata (eng_data),
    .cnt   (fifo_cnt),
    .full  (fifo_full)
  );

  hmf_seq #(.BLK(BLOCK_WORDS), .CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .init      (init_pulse),
    .fin_go    (fin_go),
    .cnt       (fifo_cnt),
    .eng_ready (eng_ready),
    .eng_done  (eng_done),
    .eng_valid (eng_valid),
    .eng_last  (eng_last),
    .eng_final (eng_final),
    .eng_empty (eng_empty),
    .pop       (pop),
    .accept    (accept),
    .busy      (busy),
    .out_set   (out_set)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dtype_q   <= DT_WORD;
      dma_en_q  <= 1'b0;
      multi_q   <= 1'b0;
      nbits_q   <= '0;
      ie_q      <= '0;
      out_rdy_q <= 1'b0;
      irq_q     <= 1'b0;
      dma_req_q <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        dtype_q  <= dtype_e'(wr_data[CB_DT +: 2]);
        dma_en_q <= wr_data[CB_DMA] && !wr_data[CB_ABORT];
        multi_q  <= wr_data[CB_MULTI];
      end
      if (start_wr) nbits_q <= wr_data[4:0];
      if (wr_fire && wr_addr == RA_MASK) ie_q <= wr_data[1:0];
      if (init_pulse)    out_rdy_q <= 1'b0;
      else if (out_set)  out_rdy_q <= 1'b1;
      else if (stat_clr) out_rdy_q <= 1'b0;
      irq_q     <= (ie_q[0] && din_ok) || (ie_q[1] && out_rdy_q);
      dma_req_q <= dma_en_q && din_ok && ((FULLC - fifo_cnt) >= BURSTC);
      restart_q <= init_pulse;
    end
  end

  assign stat_flags  = {busy, dma_en_q, out_rdy_q, din_ok};
  assign irq         = irq_q;
  assign dma_req     = dma_req_q;
  assign eng_restart = restart_q;
  assign eng_nbits   = nbits_q;
endmodule

// File: rtl/hmf_checker.sv
module hmf_checker #(
  parameter int BLK   = 16,
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          init_pulse,
  input logic          stat_clr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          din_sel,
  input logic          eng_valid,
  input logic          eng_ready,
  input logic          eng_last,
  input logic          eng_final,
  input logic          eng_empty,
  input logic          eng_done,
  input logic          st_busy,
  input logic          st_out,
  input logic          dma_req,
  input logic [CW-1:0] cnt
);
  localparam int SW = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [SW-1:0] LAST_IDX = SW'(BLK - 1);
  localparam logic [CW-1:0] REL      = CW'(BLK + 1);
  localparam logic [CW-1:0] DEPTHC   = CW'(DEPTH);

  logic [SW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (rst || init_pulse) beat_q <= '0;
    else if (eng_valid && eng_ready && !eng_final)
      beat_q <= (beat_q == LAST_IDX) ? '0 : beat_q + 1'b1;
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTHC);

  a_r5_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && din_sel && cnt == DEPTHC) |-> !wr_ready);

  a_r3_extra_word: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_final && !$past(eng_valid)) |-> ($past(cnt) >= REL));

  a_r4_last_position: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_final) |-> (eng_last == (beat_q == LAST_IDX)));

  a_r6_empty_marks_end: assert property (@(posedge clk) disable iff (rst)
    eng_empty |-> (eng_final && eng_last));

  a_r7_busy_when_feeding: assert property (@(posedge clk) disable iff (rst)
    eng_valid |-> st_busy);

  a_r8_out_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !eng_done) |=> !st_out);

  a_r10_req_quiet_in_final: assert property (@(posedge clk) disable iff (rst)
    eng_final |-> !dma_req);
endmodule

bind hash_msg_frontend hmf_checker #(
  .BLK   (BLOCK_WORDS),
  .DEPTH (FIFO_DEPTH),
  .CW    (CW)
) u_hmf_chk (
  .clk        (clk),
  .rst        (rst),
  .init_pulse (init_pulse),
  .stat_clr   (stat_clr),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .din_sel    (din_sel),
  .eng_valid  (eng_valid),
  .eng_ready  (eng_ready),
  .eng_last   (eng_last),
  .eng_final  (eng_final),
  .eng_empty  (eng_empty),
  .eng_done   (eng_done),
  .st_busy    (stat_flags[3]),
  .st_out     (stat_flags[1]),
  .dma_req    (dma_req),
  .cnt        (fifo_cnt)
);

// File: tb/tb_hash_msg_frontend.sv
module tb_hash_msg_frontend;
  import hmf_pkg::*;

  localparam int BW = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  stat_flags;
  logic        irq, dma_req, eng_restart;
  logic        dma_end = 1'b0;
  logic        eng_valid, eng_last, eng_final, eng_empty;
  logic        eng_ready = 1'b1;
  logic        eng_done = 1'b0;
  logic [31:0] eng_data;
  logic [4:0]  eng_nbits;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] bd [64];
  logic        bl [64];
  logic        bf [64];
  logic        be [64];
  logic [4:0]  bn [64];
  int          nb = 0;

  hash_msg_frontend #(.BLOCK_WORDS(BW)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .stat_flags(stat_flags),
    .irq(irq), .dma_req(dma_req), .dma_end(dma_end),
    .eng_restart(eng_restart), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_data(eng_data), .eng_last(eng_last), .eng_final(eng_final),
    .eng_empty(eng_empty), .eng_nbits(eng_nbits), .eng_done(eng_done)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst && eng_valid && eng_ready) begin
      bd[nb % 64] <= eng_data;
      bl[nb % 64] <= eng_last;
      bf[nb % 64] <= eng_final;
      be[nb % 64] <= eng_empty;
      bn[nb % 64] <= eng_nbits;
      nb <= nb + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  function automatic logic [31:0] wd(input int k);
    return (32'(k) * 32'h0103_0507) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] reord(input int dt, input logic [31:0] w);
    logic [31:0] r;
    case (dt)
      1: r = {w[15:0], w[31:16]};
      2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      3: for (int i = 0; i < 32; i++) r[i] = w[31-i];
      default: r = w;
    endcase
    return r;
  endfunction

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 status", 32'(stat_flags), 32'h1);
    check("R1 eng_valid", 32'(eng_valid), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 dma_req", 32'(dma_req), 32'h0);

    // R3 / R4 release with one word held back
    wr(RA_CTRL, 32'h4);
    base = nb;
    for (int k = 0; k < BW; k++) wr(RA_DIN, wd(k));
    idle(6);
    check("R3 no beat with one block queued", 32'(nb - base), 32'd0);
    check("R3 busy clear", 32'(stat_flags[3]), 32'd0);
    wr(RA_DIN, wd(BW));
    idle(8);
    check("R3 block released", 32'(nb - base), 32'(BW));
    for (int k = 0; k < BW; k++) begin
      check("R4 block data", bd[(base + k) % 64], wd(k));
      check("R4 last flag", 32'(bl[(base + k) % 64]), 32'(k == BW - 1));
      check("R4 not final", 32'(bf[(base + k) % 64]), 32'd0);
    end
    for (int k = BW + 1; k < 2 * BW; k++) wr(RA_DIN, wd(k));
    idle(6);
    check("R4 next block waits", 32'(nb - base), 32'(BW));
    wr(RA_DIN, wd(2 * BW));
    idle(8);
    check("R4 second block", 32'(nb - base), 32'(2 * BW));
    for (int k = 0; k < BW; k++)
      check("R4 second data", bd[(base + BW + k) % 64], wd(BW + k));

    // R6 / R7 final with partial word
    base = nb;
    wr(RA_START, 32'h0000_0118);
    idle(4);
    check("R6 one final beat", 32'(nb - base), 32'd1);
    check("R6 final data", bd[base % 64], wd(2 * BW));
    check("R6 final flags", {29'd0, bl[base % 64], bf[base % 64], be[base % 64]}, 32'b110);
    check("R6 nbits", 32'(bn[base % 64]), 32'd24);
    check("R7 busy while waiting", 32'(stat_flags[3:1]), 32'b100);
    pulse_done();
    idle(1);
    check("R7 done sets output-ready", 32'(stat_flags[3:1]), 32'b001);
    wr(RA_STAT, 32'h0);
    idle(1);
    check("R8 status write clears", 32'(stat_flags[1]), 32'd0);

    // R6 empty message, R8 init clears
    wr(RA_CTRL, 32'h4);
    base = nb;
    wr(RA_START, 32'h100);
    idle(4);
    check("R6 empty beat count", 32'(nb - base), 32'd1);
    check("R6 empty flags", {29'd0, bl[base % 64], bf[base % 64], be[base % 64]}, 32'b111);
    pulse_done();
    idle(1);
    check("R7 output-ready after empty", 32'(stat_flags[1]), 32'd1);
    wr(RA_CTRL, 32'h4);
    idle(1);
    check("R8 init clears", 32'(stat_flags[1]), 32'd0);

    // R2 reorder sweep
    for (int dt = 0; dt < 4; dt++) begin
      for (int p = 0; p < 3; p++) begin
        wr(RA_CTRL, 32'h4 | (32'(dt) << 4));
        base = nb;
        for (int k = 0; k <= BW; k++) wr(RA_DIN, wd(17 * p + k + 3));
        idle(8);
        for (int k = 0; k < BW; k++)
          check("R2 reorder", bd[(base + k) % 64], reord(dt, wd(17 * p + k + 3)));
      end
    end

    // R5 hold-off with full buffer
    wr(RA_CTRL, 32'h4);
    eng_ready = 1'b0;
    base = nb;
    for (int k = 0; k < 2 * BW; k++) wr(RA_DIN, wd(40 + k));
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = RA_DIN;
    wr_data  = wd(40 + 2 * BW);
    #1;
    check("R5 wr_ready low when full", 32'(wr_ready), 32'd0);
    check("R5 input-ready low", 32'(stat_flags[0]), 32'd0);
    wr_valid = 1'b0;
    eng_ready = 1'b1;
    wr(RA_DIN, wd(40 + 2 * BW));
    idle(14);
    check("R5 two blocks out", 32'(nb - base), 32'(2 * BW));
    for (int k = 0; k < 2 * BW; k++)
      check("R5 order kept", bd[(base + k) % 64], wd(40 + k));
    base = nb;
    wr(RA_START, 32'h100);
    idle(4);
    check("R5 held word delivered", bd[base % 64], wd(40 + 2 * BW));
    pulse_done();

    // R9 init mid-message
    wr(RA_CTRL, 32'h4);
    base = nb;
    for (int k = 0; k < 3; k++) wr(RA_DIN, wd(90 + k));
    wr(RA_CTRL, 32'h4);
    for (int k = 0; k < BW; k++) wr(RA_DIN, wd(100 + k));
    idle(6);
    check("R9 fresh count after init", 32'(nb - base), 32'd0);
    wr(RA_DIN, wd(100 + BW));
    idle(8);
    check("R9 first block after init", bd[base % 64], wd(100));

    // R10 / R11 DMA
    wr(RA_CTRL, 32'hC);
    idle(3);
    check("R10 request with space", 32'(dma_req), 32'd1);
    check("R11 status DMA bit", 32'(stat_flags[2]), 32'd1);
    eng_ready = 1'b0;
    base = nb;
    for (int k = 0; k <= BW; k++) wr(RA_DIN, wd(120 + k));
    idle(3);
    check("R10 no request when space short", 32'(dma_req), 32'd0);
    eng_ready = 1'b1;
    idle(8);
    check("R10 request again", 32'(dma_req), 32'd1);
    base = nb;
    @(negedge clk);
    dma_end = 1'b1;
    @(negedge clk);
    dma_end = 1'b0;
    idle(3);
    check("R11 end starts final", 32'(nb - base), 32'd1);
    check("R11 final data", bd[base % 64], wd(120 + BW));
    check("R10 no request in final", 32'(dma_req), 32'd0);
    pulse_done();
    wr(RA_CTRL, 32'h200C);
    base = nb;
    wr(RA_DIN, wd(130));
    wr(RA_DIN, wd(131));
    @(negedge clk);
    dma_end = 1'b1;
    @(negedge clk);
    dma_end = 1'b0;
    idle(5);
    check("R11 multi mode ignores end", 32'(nb - base), 32'd0);
    check("R11 multi mode not busy", 32'(stat_flags[3]), 32'd0);
    wr(RA_CTRL, 32'h4008);
    idle(2);
    check("R11 abort clears DMA bit", 32'(stat_flags[2]), 32'd0);
    check("R11 abort drops request", 32'(dma_req), 32'd0);
    wr(RA_START, 32'h100);
    idle(5);
    check("R11 tail words", 32'(nb - base), 32'd2);
    check("R11 tail data", bd[(base + 1) % 64], wd(131));
    pulse_done();

    // R12 interrupt
    wr(RA_MASK, 32'h1);
    idle(2);
    check("R12 input-ready irq", 32'(irq), 32'd1);
    wr(RA_MASK, 32'h2);
    idle(2);
    check("R12 completion irq", 32'(irq), 32'd1);
    wr(RA_STAT, 32'h0);
    idle(2);
    check("R12 irq low after clear", 32'(irq), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule